// File: doc/BRIEF.md
# Cascaded Interrupt Controller Acknowledge Path

This block models a pair of 8-input priority interrupt controllers wired in cascade: a primary stage that talks to the CPU and a secondary stage whose combined request is folded into primary input 2. Sixteen request lines come in. Line numbers with bit 3 set go to the secondary stage, at position N modulo 8. Each stage keeps one pending bit per line. A per-stage trigger-mode register picks, line by line, whether the input is edge sensitive (0) or level sensitive (1).

The CPU sees a single request output. It answers with an acknowledge strobe. The acknowledge always resolves through the primary stage first. Within a stage the lowest-numbered pending line wins, and there is no rotation. When the winner is the cascade input, the secondary stage resolves as well. One cycle after the strobe, the block returns the interrupt vector and the resolved line number (0 to 15), together with a valid flag. The vector is the stage's base value plus the line position.

Where a stage has nothing pending, it reports position 7 in place of a real line.

Top module: `casc_irq_ack`

## Requirements
- R1: Request line N (0..15) feeds the secondary stage when N[3] = 1 and the primary stage otherwise, at position N[2:0]. The reported line is the position for a primary hit and 8 plus the position for a secondary hit.
- R2: Within each stage the pending line with the lowest position is chosen at acknowledge. The primary stage has priority over all secondary lines, except through its position 2.
- R3: An edge-mode line (trigger bit 0) becomes pending only when its input goes from 0 to 1. It stays pending until it is acknowledged, whatever the input does. An input held high does not make it pending again after acknowledge.
- R4: A level-mode line (trigger bit 1) is pending exactly while its input is high, including right after it is acknowledged.
- R5: Whenever any secondary line is pending, primary position 2 is made pending in the same cycle. An acknowledge that resolves to a secondary line returns vector = secondary base + position and line = 8 + position, and clears only that secondary line.
- R6: If the primary stage picks position 2 while no secondary line is pending, the result is vector = secondary base + 7 and line 15.
- R7: If no primary line is pending at acknowledge, the result is vector = primary base + 7 and line 7, and no pending bit changes.
- R8: A primary hit on a position other than 2 returns vector = primary base + position and clears only that primary line. Vectors wrap modulo 256.
- R9: A write with ctl_sel_i = 0 loads the primary trigger register with data AND 0xF8. A write with ctl_sel_i = 1 loads the secondary trigger register with data AND 0xDE. Both registers are readable on their output ports.
- R10: int_o is high exactly when some primary line is pending. It reflects each request change and each acknowledge from the cycle after the clock edge that took it.
- R11: ack_valid_o is high in the cycle after each clock edge with ack_i high, and low otherwise.
- R12: After reset, no line is pending, both trigger registers are 0 (all edge), int_o is 0 and ack_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Request lines; bit N is line N |
| ctl_we_i | input | 1 | Trigger-mode register write strobe |
| ctl_sel_i | input | 1 | 0 selects the primary register, 1 the secondary |
| ctl_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| ctl_master_o | output | 8 | Primary trigger-mode register |
| ctl_slave_o | output | 8 | Secondary trigger-mode register |
| master_base_i | input | 8 | Primary vector base |
| slave_base_i | input | 8 | Secondary vector base |
| ack_i | input | 1 | Acknowledge strobe from the CPU |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_vector_o | output | 8 | Returned vector |
| ack_line_o | output | 4 | Resolved line number |
| int_o | output | 1 | Request to the CPU |

## Verification
The bench uses the default parameters: 8 lines per stage, an 8-bit vector and the trigger masks 0xF8 and 0xDE. With these values every one of the 16 lines can be driven. The bench can check that lines 0-2 of the primary stage and lines 0 and 5 of the secondary stage stay edge-only. It also reaches the cascade position and the position-7 fallback in both stages.

Vector bases are chosen near the top of the 8-bit range in random phases, so that the base-plus-position sum wraps.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    // Which stage a trigger-mode register write targets.
    typedef enum logic {
        SEL_PRIMARY   = 1'b0,
        SEL_SECONDARY = 1'b1
    } stage_sel_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the lowest set position wins.
module irq_prio_pick #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [LINES-1:0] grant_o
);

    logic [LINES-1:0] lower_any;

    assign lower_any[0] = 1'b0;
    for (genvar g = 1; g < LINES; g++) begin : g_chain
        assign lower_any[g] = lower_any[g-1] | pend_i[g-1];
    end

    assign grant_o = pend_i & ~lower_any;
    assign any_o   = |pend_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_stage.sv
// One controller stage: pending bits, previous input levels and the
// trigger-mode register. casc_i forces a rising edge on CASC_PIN.
module irq_stage #(
    parameter int unsigned      LINES    = 8,
    parameter logic [LINES-1:0] CTL_MASK = '1,
    parameter int unsigned      CASC_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic             ctl_we_i,
    input  logic [LINES-1:0] ctl_wdata_i,
    input  logic [LINES-1:0] clr_i,
    input  logic             casc_i,
    output logic [LINES-1:0] pend_o,
    output logic [LINES-1:0] pend_next_o,
    output logic [LINES-1:0] ctl_o
);

    typedef struct packed {
        logic [LINES-1:0] pend;
        logic [LINES-1:0] last;
        logic [LINES-1:0] ctl;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LINES; i++) begin
            logic casc_hit;
            casc_hit = (i == int'(CASC_PIN)) && casc_i;
            if (st_q.ctl[i]) begin
                st_d.pend[i] = lines_i[i] | casc_hit;
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~clr_i[i])
                             | (lines_i[i] & ~st_q.last[i])
                             | casc_hit;
            end
        end
        st_d.last = lines_i;
        if (ctl_we_i) st_d.ctl = ctl_wdata_i & CTL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o      = st_q.pend;
    assign pend_next_o = st_d.pend;
    assign ctl_o       = st_q.ctl;

endmodule

// File: rtl/casc_irq_ack.sv
module casc_irq_ack
    import casc_irq_pkg::*;
#(
    parameter int unsigned      LINES         = 8,
    parameter int unsigned      VEC_W         = 8,
    parameter logic [LINES-1:0] PRI_CTL_MASK  = 8'hF8,
    parameter logic [LINES-1:0] SEC_CTL_MASK  = 8'hDE,
    parameter int unsigned      CASC_PIN      = 2,
    parameter int unsigned      FALLBACK_PIN  = 7,
    localparam int unsigned     IDX_W         = $clog2(LINES),
    localparam int unsigned     LINE_W        = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LINES-1:0] req_i,
    input  logic               ctl_we_i,
    input  logic               ctl_sel_i,
    input  logic [LINES-1:0]   ctl_wdata_i,
    output logic [LINES-1:0]   ctl_master_o,
    output logic [LINES-1:0]   ctl_slave_o,
    input  logic [VEC_W-1:0]   master_base_i,
    input  logic [VEC_W-1:0]   slave_base_i,
    input  logic               ack_i,
    output logic               ack_valid_o,
    output logic [VEC_W-1:0]   ack_vector_o,
    output logic [LINE_W-1:0]  ack_line_o,
    output logic               int_o
);

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  vec;
        logic [LINE_W-1:0] line;
    } ack_t;

    stage_sel_e       sel;
    logic [LINES-1:0] p_pend, p_next, p_clr, p_grant;
    logic [LINES-1:0] s_pend, s_next, s_clr, s_grant;
    logic             p_any, s_any;
    logic [IDX_W-1:0] p_idx, s_idx;
    ack_t             ack_d, ack_q;

    assign sel = stage_sel_e'(ctl_sel_i);

    irq_stage #(
        .LINES(LINES), .CTL_MASK(SEC_CTL_MASK), .CASC_PIN(CASC_PIN)
    ) u_sec (
        .clk(clk), .rst_n(rst_n),
        .lines_i(req_i[2*LINES-1:LINES]),
        .ctl_we_i(ctl_we_i && sel == SEL_SECONDARY),
        .ctl_wdata_i(ctl_wdata_i),
        .clr_i(s_clr), .casc_i(1'b0),
        .pend_o(s_pend), .pend_next_o(s_next), .ctl_o(ctl_slave_o)
    );

    irq_stage #(
        .LINES(LINES), .CTL_MASK(PRI_CTL_MASK), .CASC_PIN(CASC_PIN)
    ) u_pri (
        .clk(clk), .rst_n(rst_n),
        .lines_i(req_i[LINES-1:0]),
        .ctl_we_i(ctl_we_i && sel == SEL_PRIMARY),
        .ctl_wdata_i(ctl_wdata_i),
        .clr_i(p_clr), .casc_i(|s_next),
        .pend_o(p_pend), .pend_next_o(p_next), .ctl_o(ctl_master_o)
    );

    irq_prio_pick #(.LINES(LINES)) u_pick_pri (
        .pend_i(p_pend), .any_o(p_any), .idx_o(p_idx), .grant_o(p_grant)
    );

    irq_prio_pick #(.LINES(LINES)) u_pick_sec (
        .pend_i(s_pend), .any_o(s_any), .idx_o(s_idx), .grant_o(s_grant)
    );

    // Acknowledge resolution: primary first, secondary behind CASC_PIN.
    always_comb begin
        ack_d       = ack_q;
        ack_d.valid = ack_i;
        p_clr       = '0;
        s_clr       = '0;
        if (ack_i) begin
            if (!p_any) begin
                ack_d.vec  = master_base_i + VEC_W'(FALLBACK_PIN);
                ack_d.line = LINE_W'(FALLBACK_PIN);
            end else begin
                p_clr = p_grant;
                if (p_idx == IDX_W'(CASC_PIN)) begin
                    if (s_any) begin
                        s_clr      = s_grant;
                        ack_d.vec  = slave_base_i + VEC_W'(s_idx);
                        ack_d.line = {1'b1, s_idx};
                    end else begin
                        ack_d.vec  = slave_base_i + VEC_W'(FALLBACK_PIN);
                        ack_d.line = {1'b1, IDX_W'(FALLBACK_PIN)};
                    end
                end else begin
                    ack_d.vec  = master_base_i + VEC_W'(p_idx);
                    ack_d.line = {1'b0, p_idx};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign ack_valid_o  = ack_q.valid;
    assign ack_vector_o = ack_q.vec;
    assign ack_line_o   = ack_q.line;
    assign int_o        = |p_pend;

    // p_next is exposed by the stage for symmetry; fold it into nothing else.
    logic unused_p_next;
    assign unused_p_next = ^p_next;

endmodule

// File: rtl/casc_irq_ack_chk.sv
module casc_irq_ack_chk #(
    parameter int unsigned      LINES        = 8,
    parameter int unsigned      VEC_W        = 8,
    parameter logic [LINES-1:0] PRI_CTL_MASK = 8'hF8,
    parameter logic [LINES-1:0] SEC_CTL_MASK = 8'hDE,
    parameter int unsigned      FALLBACK_PIN = 7,
    localparam int unsigned     LINE_W       = $clog2(LINES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we_i,
    input logic              ctl_sel_i,
    input logic [LINES-1:0]  ctl_wdata_i,
    input logic [LINES-1:0]  ctl_master_o,
    input logic [LINES-1:0]  ctl_slave_o,
    input logic [VEC_W-1:0]  master_base_i,
    input logic [VEC_W-1:0]  slave_base_i,
    input logic              ack_i,
    input logic              ack_valid_o,
    input logic [VEC_W-1:0]  ack_vector_o,
    input logic [LINE_W-1:0] ack_line_o,
    input logic              int_o
);

    a_r11_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> ack_valid_o);

    a_r11_no_valid_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !ack_valid_o);

    a_r7_empty_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o) |=> (ack_line_o == LINE_W'(FALLBACK_PIN)
            && ack_vector_o == VEC_W'($past(master_base_i) + VEC_W'(FALLBACK_PIN))));

    a_r8_primary_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (ack_line_o[LINE_W-1]
            || ack_vector_o == VEC_W'($past(master_base_i) + VEC_W'(ack_line_o[LINE_W-2:0]))));

    a_r5_secondary_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (!ack_line_o[LINE_W-1]
            || ack_vector_o == VEC_W'($past(slave_base_i) + VEC_W'(ack_line_o[LINE_W-2:0]))));

    a_r9_primary_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && !ctl_sel_i) |=> ctl_master_o == ($past(ctl_wdata_i) & PRI_CTL_MASK));

    a_r9_secondary_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && ctl_sel_i) |=> ctl_slave_o == ($past(ctl_wdata_i) & SEC_CTL_MASK));

endmodule

bind casc_irq_ack casc_irq_ack_chk #(
    .LINES(LINES), .VEC_W(VEC_W), .PRI_CTL_MASK(PRI_CTL_MASK),
    .SEC_CTL_MASK(SEC_CTL_MASK), .FALLBACK_PIN(FALLBACK_PIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we_i), .ctl_sel_i(ctl_sel_i),
    .ctl_wdata_i(ctl_wdata_i), .ctl_master_o(ctl_master_o),
    .ctl_slave_o(ctl_slave_o), .master_base_i(master_base_i),
    .slave_base_i(slave_base_i), .ack_i(ack_i), .ack_valid_o(ack_valid_o),
    .ack_vector_o(ack_vector_o), .ack_line_o(ack_line_o), .int_o(int_o)
);

// File: tb/casc_irq_ack_tb.sv
module casc_irq_ack_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        ctl_we = 1'b0, ctl_sel = 1'b0;
    logic [7:0]  ctl_wd = '0;
    logic [7:0]  ctl_m, ctl_s;
    logic [7:0]  mbase = 8'h20, sbase = 8'h70;
    logic        ack = 1'b0;
    logic        vld, intr;
    logic [7:0]  vec;
    logic [3:0]  line;

    int checks = 0, errors = 0;

    // Bench reference state, built from the requirements.
    logic [7:0]  m_pend = '0, s_pend = '0, m_ctl = '0, s_ctl = '0;
    logic [15:0] last = '0;
    logic [7:0]  exp_vec;
    logic [3:0]  exp_line;

    always #10 clk = ~clk;

    casc_irq_ack u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ctl_we_i(ctl_we),
        .ctl_sel_i(ctl_sel), .ctl_wdata_i(ctl_wd), .ctl_master_o(ctl_m),
        .ctl_slave_o(ctl_s), .master_base_i(mbase), .slave_base_i(sbase),
        .ack_i(ack), .ack_valid_o(vld), .ack_vector_o(vec),
        .ack_line_o(line), .int_o(intr)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    // One clock: drive at negedge, update the reference, compare next negedge.
    task automatic step(input logic [15:0] r, input bit a,
                        input bit we = 0, input bit sel = 0, input logic [7:0] wd = '0);
        logic [7:0] mclr, sclr, mn, sn;
        int mi, si;
        req = r; ack = a; ctl_we = we; ctl_sel = sel; ctl_wd = wd;
        mclr = '0; sclr = '0;
        if (a) begin
            mi = lowest(m_pend);
            if (mi < 0) begin
                exp_vec = mbase + 8'd7; exp_line = 4'd7;
            end else begin
                mclr[mi] = 1'b1;
                if (mi == 2) begin
                    si = lowest(s_pend);
                    if (si < 0) begin
                        exp_vec = sbase + 8'd7; exp_line = 4'd15;
                    end else begin
                        sclr[si] = 1'b1;
                        exp_vec = sbase + 8'(si); exp_line = 4'(8 + si);
                    end
                end else begin
                    exp_vec = mbase + 8'(mi); exp_line = 4'(mi);
                end
            end
        end
        for (int i = 0; i < 8; i++) begin
            sn[i] = s_ctl[i] ? r[8+i] : ((s_pend[i] & ~sclr[i]) | (r[8+i] & ~last[8+i]));
            mn[i] = m_ctl[i] ? r[i]   : ((m_pend[i] & ~mclr[i]) | (r[i] & ~last[i]));
        end
        mn[2] = mn[2] | (|sn);
        m_pend = mn; s_pend = sn; last = r;
        if (we && !sel) m_ctl = wd & 8'hF8;
        if (we && sel)  s_ctl = wd & 8'hDE;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0; ctl_we = 1'b0;
        chk(vld == a, "R11", "ack valid", int'(vld), int'(a));
        if (a) begin
            chk(vec == exp_vec, "R5 R6 R7 R8", "vector", int'(vec), int'(exp_vec));
            chk(line == exp_line, "R1 R2", "line", int'(line), int'(exp_line));
        end
        chk(intr == (|m_pend), "R10", "int_o", int'(intr), int'(|m_pend));
        chk(ctl_m == m_ctl && ctl_s == s_ctl, "R9", "trigger regs",
            int'({ctl_m, ctl_s}), int'({m_ctl, s_ctl}));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(intr == 1'b0, "R12", "int_o at reset", int'(intr), 0);
        chk(vld == 1'b0, "R12", "valid at reset", int'(vld), 0);
        chk(ctl_m == 8'h00 && ctl_s == 8'h00, "R12", "trigger regs at reset",
            int'({ctl_m, ctl_s}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 masked writes
        step(16'h0, 0, 1, 0, 8'hFF);
        chk(ctl_m == 8'hF8, "R9", "primary mask", int'(ctl_m), 8'hF8);
        step(16'h0, 0, 1, 1, 8'hFF);
        chk(ctl_s == 8'hDE, "R9", "secondary mask", int'(ctl_s), 8'hDE);
        step(16'h0, 0, 1, 0, 8'h00);
        step(16'h0, 0, 1, 1, 8'h00);

        // R7 empty acknowledge
        step(16'h0, 1);
        chk(vec == 8'h27 && line == 4'd7, "R7", "empty ack", int'({vec, line}), 12'h277);

        // R3 / R8 / R10 edge line on primary position 5
        step(16'h0020, 0);
        chk(intr == 1'b1, "R10", "int after edge", int'(intr), 1);
        step(16'h0020, 1);
        chk(vec == 8'h25 && line == 4'd5, "R8", "primary hit", int'({vec, line}), 12'h255);
        chk(intr == 1'b0, "R10", "int after ack", int'(intr), 0);
        step(16'h0020, 1);
        chk(line == 4'd7, "R3", "held-high edge line not relatched", int'(line), 7);

        // R2 primary priority
        step(16'h0050, 0);
        step(16'h0050, 1);
        chk(line == 4'd4, "R2", "lowest primary first", int'(line), 4);
        step(16'h0000, 1);
        chk(line == 4'd6, "R3", "edge stays pending after input falls", int'(line), 6);

        // R5 / R1 secondary path
        step(16'h0800, 0);
        chk(intr == 1'b1, "R5", "cascade raises int", int'(intr), 1);
        step(16'h0800, 1);
        chk(vec == 8'h73 && line == 4'd11, "R5", "secondary hit", int'({vec, line}), 12'h73B);
        chk(intr == 1'b0, "R5", "int after secondary ack", int'(intr), 0);
        step(16'h2200, 0);
        step(16'h2200, 1);
        chk(line == 4'd9, "R1", "secondary lowest first", int'(line), 9);
        step(16'h2200, 1);
        chk(line == 4'd13, "R1", "secondary next", int'(line), 13);

        // R6 cascade position with empty secondary
        step(16'h0004, 0);
        step(16'h0000, 1);
        chk(vec == 8'h77 && line == 4'd15, "R6", "empty secondary", int'({vec, line}), 12'h77F);

        // R4 level line on primary position 3
        step(16'h0000, 0, 1, 0, 8'h08);
        step(16'h0008, 0);
        step(16'h0008, 1);
        chk(line == 4'd3, "R4", "level hit", int'(line), 3);
        chk(intr == 1'b1, "R4", "level still pending after ack", int'(intr), 1);
        step(16'h0000, 0);
        chk(intr == 1'b0, "R4", "level drops with input", int'(intr), 0);
        step(16'h0000, 0, 1, 0, 8'h00);

        // R2 primary over secondary
        step(16'h0102, 0);
        step(16'h0102, 1);
        chk(line == 4'd1, "R2", "primary 1 before secondary", int'(line), 1);
        step(16'h0102, 1);
        chk(line == 4'd8, "R2", "then secondary 0", int'(line), 8);

        // Random phase with wrapping bases
        mbase = 8'hF8; sbase = 8'hFC;
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] r;
            r = req;
            if ($urandom_range(0, 3) == 0) r = r ^ 16'($urandom);
            if ($urandom_range(0, 40) == 0) begin
                mbase = 8'($urandom); sbase = 8'($urandom);
            end
            if ($urandom_range(0, 30) == 0)
                step(r, $urandom_range(0, 2) == 0, 1, 1'($urandom), 8'($urandom));
            else
                step(r, $urandom_range(0, 2) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule